// File: doc/BRIEF.md
# Parallel Multi-Lane LED Waveform Generator

This block drives up to sixteen single-wire serial LED chains side by side at an 800 kHz bit rate. It does not serialise each chain on its own. It reads bit-plane words, where each word carries one bit position for every lane. All lanes then share a single three-phase slot of 60 clocks at 48 MHz. First every enabled lane is raised. At count 12 each lane takes its own data bit. At count 31 every lane is pulled low. A 0 bit therefore gives a short high pulse and a 1 bit gives a long one, and all lanes switch together. Adding lanes costs no extra time.

A frame is started with a length in LEDs and a lane mask, and both are latched when the start is accepted. A frame is made of three parts:
- two silent lead-in slots;
- 24 data slots per LED, each fetched from a bit-plane memory through a request/valid pair;
- one silent trailing slot.

After the frame, all lanes stay low for a 2640-cycle reset guard. The done level then rises.

Top module: `led_lane_gen`

## Requirements
- R1: After reset, every lane output, `done_o` and `word_req_o` are low.
- R2: In a data slot, an enabled lane rises one cycle after slot count 0. A 0 bit gives a high pulse of 12 cycles and a 1 bit gives one of 31 cycles. Slots repeat every 60 cycles.
- R3: Bit `l` of the k-th data word (k counted from 0 within the frame) sets the width of the k-th pulse on lane `l`. All enabled lanes rise in the same cycle.
- R4: A lane whose bit is 0 in the mask latched at the accepted start stays low for the whole frame. A mask change after the start has no effect.
- R5: A frame of N LEDs holds exactly 24·N data slots. Two silent slots come before them and one comes after. The first lane rise is 121 cycles after the clock edge that accepts the start.
- R6: `done_o` rises 60·(24·N+3)+2640 cycles after the accepting edge, and all lanes stay low during the guard.
- R7: A start that arrives while a frame or its guard is in progress is ignored. It changes neither the pulse train nor the done timing.
- R8: `done_o` is a level that stays high until a start is accepted. It is low in the cycle after that start is accepted.
- R9: `word_req_o` is a one-cycle pulse at slot count 0 of each data slot, so a frame issues 24·N pulses. A word that `word_vld_i` delivers before count 12 is used for that slot. A slot whose word has not arrived sends 0 bits.
- R10: A frame with N = 0 issues no request and no pulse, and completes after 180+2640 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| num_leds_i | input | LED_W | Frame length in LEDs, latched on start |
| lane_en_i | input | N_LANES | Lane mask, latched on start |
| word_req_o | output | 1 | Request for the next bit-plane word |
| word_i | input | N_LANES | Bit-plane word, one bit per lane |
| word_vld_i | input | 1 | `word_i` holds the requested word |
| lane_o | output | N_LANES | Serial line for each lane |
| done_o | output | 1 | Frame and guard complete |

## Verification
The embedded assertions check the rules that hold on every cycle:
- masked lanes stay low;
- every lane falls after the final phase;
- all lanes are low in the guard;
- the slot counter wraps;
- a request comes well before the data phase;
- a busy start leaves the sequencer alone;
- done rises only out of the guard and clears on an accepted start.

Some properties depend on a whole frame and only the bench scenarios show them:
- the exact pulse widths per data bit, in bit-plane order;
- the lockstep first rise;
- the number of requests;
- the exact cycle on which done rises;
- the empty frame.

// File: rtl/led_pkg.sv
`timescale 1ns/1ps
package led_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GUARD} seq_state_e;
endpackage

// File: rtl/led_slot_timer.sv
`timescale 1ns/1ps
module led_slot_timer #(
  parameter int SLOT_CYC = 60,
  parameter int T_DATA   = 12,
  parameter int T_LOW    = 31,
  localparam int CNT_W   = $clog2(SLOT_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             slot_start_o,
  output logic             ph_data_o,
  output logic             ph_low_o,
  output logic             slot_end_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!run_i)                          cnt_q <= '0;
    else if (cnt_q == CNT_W'(SLOT_CYC - 1))   cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o        = cnt_q;
  assign slot_start_o = run_i && cnt_q == '0;
  assign ph_data_o    = run_i && cnt_q == CNT_W'(T_DATA);
  assign ph_low_o     = run_i && cnt_q == CNT_W'(T_LOW);
  assign slot_end_o   = run_i && cnt_q == CNT_W'(SLOT_CYC - 1);

  assert_slot_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q == CNT_W'(SLOT_CYC - 1)) |=> cnt_q == '0);
endmodule

// File: rtl/led_frame_seq.sv
`timescale 1ns/1ps
module led_frame_seq import led_pkg::*; #(
  parameter int LED_W        = 8,
  parameter int BITS_PER_LED = 24,
  parameter int LEAD_SLOTS   = 2,
  parameter int TRAIL_SLOTS  = 1,
  parameter int GUARD_CYC    = 2640,
  localparam int MAX_SLOTS   = LEAD_SLOTS + BITS_PER_LED * ((1 << LED_W) - 1) + TRAIL_SLOTS,
  localparam int IDX_W       = $clog2(MAX_SLOTS + 1),
  localparam int GRD_W       = $clog2(GUARD_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LED_W-1:0] num_leds_i,
  input  logic             slot_start_i,
  input  logic             slot_end_i,
  output seq_state_e       state_o,
  output logic             go_o,
  output logic             run_o,
  output logic             data_slot_o,
  output logic             word_req_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, data_end_q, last_q, span;
  logic [GRD_W-1:0] grd_q;
  logic             done_q;

  assign span        = IDX_W'(LEAD_SLOTS) + IDX_W'(BITS_PER_LED) * IDX_W'(num_leds_i);
  assign go_o        = start_i && state_q == ST_IDLE;
  assign run_o       = state_q == ST_RUN;
  assign data_slot_o = run_o && idx_q >= IDX_W'(LEAD_SLOTS) && idx_q < data_end_q;
  assign word_req_o  = data_slot_o && slot_start_i;
  assign state_o     = state_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      data_end_q <= '0;
      last_q     <= '0;
      grd_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_RUN;
          idx_q      <= '0;
          data_end_q <= span;
          last_q     <= span + IDX_W'(TRAIL_SLOTS) - 1'b1;
          done_q     <= 1'b0;
        end
        ST_RUN: if (slot_end_i) begin
          if (idx_q == last_q) begin
            state_q <= ST_GUARD;
            grd_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_GUARD: begin
          if (grd_q == GRD_W'(GUARD_CYC - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            grd_q <= grd_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // busy start must not disturb the slot sequence
  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i && !slot_end_i) |=> (state_q == ST_RUN && idx_q == $past(idx_q)));
  assert_done_from_guard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(state_q) == ST_GUARD);
  assert_done_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == ST_IDLE) |=> !done_q);
endmodule

// File: rtl/led_lane_drive.sv
`timescale 1ns/1ps
module led_lane_drive #(
  parameter int N_LANES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [N_LANES-1:0] lane_en_i,
  input  logic [N_LANES-1:0] word_i,
  input  logic               word_vld_i,
  input  logic               data_slot_i,
  input  logic               slot_start_i,
  input  logic               ph_data_i,
  input  logic               ph_low_i,
  output logic [N_LANES-1:0] en_o,
  output logic [N_LANES-1:0] lane_o
);
  logic [N_LANES-1:0] en_q, data_q, lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (go_i) en_q <= lane_en_i;
  end

  // a late word reads as all zeros
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           data_q <= '0;
    else if (word_vld_i)   data_q <= word_i;
    else if (slot_start_i) data_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         lane_q <= '0;
    else if (slot_start_i && data_slot_i) lane_q <= en_q;
    else if (ph_data_i && data_slot_i)    lane_q <= data_q & en_q;
    else if (ph_low_i)                    lane_q <= '0;
  end

  assign lane_o = lane_q;
  assign en_o   = en_q;

  assert_mask_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q & ~en_q) == '0);
  assert_tail_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_low_i |=> lane_q == '0);
endmodule

// File: rtl/led_lane_gen.sv
`timescale 1ns/1ps
module led_lane_gen import led_pkg::*; #(
  parameter int N_LANES      = 16,
  parameter int LED_W        = 8,
  parameter int SLOT_CYC     = 60,
  parameter int T_DATA       = 12,
  parameter int T_LOW        = 31,
  parameter int BITS_PER_LED = 24,
  parameter int LEAD_SLOTS   = 2,
  parameter int TRAIL_SLOTS  = 1,
  parameter int GUARD_CYC    = 2640,
  localparam int CNT_W       = $clog2(SLOT_CYC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LED_W-1:0]   num_leds_i,
  input  logic [N_LANES-1:0] lane_en_i,
  output logic               word_req_o,
  input  logic [N_LANES-1:0] word_i,
  input  logic               word_vld_i,
  output logic [N_LANES-1:0] lane_o,
  output logic               done_o
);
  seq_state_e         state;
  logic               go, run, data_slot, slot_start, slot_end, ph_data, ph_low;
  logic [CNT_W-1:0]   cnt;
  logic [N_LANES-1:0] en;

  led_slot_timer #(
    .SLOT_CYC(SLOT_CYC), .T_DATA(T_DATA), .T_LOW(T_LOW)
  ) i_timer (
    .clk_i, .rst_ni, .run_i(run), .cnt_o(cnt), .slot_start_o(slot_start),
    .ph_data_o(ph_data), .ph_low_o(ph_low), .slot_end_o(slot_end)
  );

  led_frame_seq #(
    .LED_W(LED_W), .BITS_PER_LED(BITS_PER_LED), .LEAD_SLOTS(LEAD_SLOTS),
    .TRAIL_SLOTS(TRAIL_SLOTS), .GUARD_CYC(GUARD_CYC)
  ) i_seq (
    .clk_i, .rst_ni, .start_i, .num_leds_i, .slot_start_i(slot_start),
    .slot_end_i(slot_end), .state_o(state), .go_o(go), .run_o(run),
    .data_slot_o(data_slot), .word_req_o, .done_o
  );

  led_lane_drive #(.N_LANES(N_LANES)) i_drive (
    .clk_i, .rst_ni, .go_i(go), .lane_en_i, .word_i, .word_vld_i,
    .data_slot_i(data_slot), .slot_start_i(slot_start), .ph_data_i(ph_data),
    .ph_low_i(ph_low), .en_o(en), .lane_o
  );

  assert_guard_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_GUARD |-> lane_o == '0);
  assert_req_early_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_req_o |-> (cnt < CNT_W'(T_DATA - 1) && state == ST_RUN));
  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_req_o |=> !word_req_o);
  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> (lane_o == '0 && !word_req_o));
endmodule

// File: tb/test_led_lane_gen.sv
`timescale 1ns/1ps
module test_led_lane_gen;
  localparam int NL = 16;
  localparam int MAXP = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    num_leds = '0;
  logic [NL-1:0] lane_en = '0;
  logic          word_req;
  logic [NL-1:0] word = '0;
  logic          word_vld = 1'b0;
  logic [NL-1:0] lane;
  logic          done;

  int nchk = 0, nfail = 0;
  int ncnt = 0, nreq = 0, done_t = -1;
  int npulse [NL];
  int first_rise [NL];
  int rise_t [NL];
  int widths [NL][MAXP];
  logic [NL-1:0] prev_lane = '0;
  logic prev_done = 1'b0;
  int ptr = 0, pat_mode = 0;

  always #5 clk = ~clk;

  led_lane_gen i_led_lane_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .num_leds_i(num_leds),
    .lane_en_i(lane_en), .word_req_o(word_req), .word_i(word),
    .word_vld_i(word_vld), .lane_o(lane), .done_o(done)
  );

  function automatic logic [NL-1:0] pat(int mode, int k);
    case (mode)
      1: return '1;
      2: return '0;
      default: return NL'((k * 40503) ^ (k << 7) ^ 16'h5A3C);
    endcase
  endfunction

  // bit-plane memory: one cycle latency
  always @(posedge clk) begin
    word_vld <= word_req;
    if (word_req) begin
      word <= pat(pat_mode, ptr);
      ptr  <= ptr + 1;
    end
  end

  always @(negedge clk) begin
    ncnt = ncnt + 1;
    for (int l = 0; l < NL; l++) begin
      if (lane[l] && !prev_lane[l]) begin
        if (first_rise[l] < 0) first_rise[l] = ncnt;
        rise_t[l] = ncnt;
      end else if (!lane[l] && prev_lane[l]) begin
        if (npulse[l] < MAXP) widths[l][npulse[l]] = ncnt - rise_t[l];
        npulse[l] = npulse[l] + 1;
      end
    end
    prev_lane = lane;
    if (word_req) nreq = nreq + 1;
    if (done && !prev_done && done_t < 0) done_t = ncnt;
    prev_done = done;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (ncnt < t) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(lane == '0, "R1 lanes in reset", int'(lane), 0);
    check(!done && !word_req, "R1 done/req in reset", int'({done, word_req}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(lane == '0 && !done && !word_req, "R1 after reset", int'(lane), 0);
  endtask

  // inject: 0 none, 1 starts during data and during guard
  task automatic run_frame(input int n, input logic [NL-1:0] en, input int mode, input int inject);
    int ts, slots, exp_done, bad_act, bad_exp, bad;
    for (int l = 0; l < NL; l++) begin
      npulse[l] = 0; first_rise[l] = -1;
    end
    nreq = 0; done_t = -1; ptr = 0; pat_mode = mode;
    @(posedge clk); #1;
    start = 1'b1; num_leds = 8'(n); lane_en = en;
    @(negedge clk); #1;
    ts = ncnt;
    @(posedge clk); #1;
    start = 1'b0; lane_en = ~en; num_leds = 8'd7;
    @(negedge clk); #1;
    check(!done, "R8 done cleared on start", int'(done), 0);
    slots = 24 * n + 3;
    exp_done = ts + 1 + 60 * slots + 2640;
    if (inject != 0) begin
      wait_until(ts + 400); #1;
      start = 1'b1; @(posedge clk); #1; start = 1'b0;
      wait_until(ts + 60 * slots + 1000); #1;
      start = 1'b1; @(posedge clk); #1; start = 1'b0;
    end
    wait_until(exp_done + 5); #1;
    check(done_t == exp_done, "R6 done timing", done_t - ts, exp_done - ts);
    check(done && lane == '0, "R8 done level held", int'(done), 1);
    check(nreq == 24 * n, "R9 request count", nreq, 24 * n);
    for (int l = 0; l < NL; l++) begin
      if (en[l]) begin
        check(npulse[l] == 24 * n, $sformatf("R5 pulses lane %0d", l), npulse[l], 24 * n);
        if (n > 0)
          check(first_rise[l] == ts + 122, $sformatf("R3 lockstep first rise lane %0d", l),
                first_rise[l] - ts, 122);
        bad = 0; bad_act = 0; bad_exp = 0;
        for (int j = 0; j < 24 * n && j < MAXP; j++) begin
          int ew;
          ew = pat(mode, j)[l] ? 31 : 12;
          if (bad == 0 && widths[l][j] != ew) begin
            bad = 1; bad_act = widths[l][j]; bad_exp = ew;
          end
        end
        check(bad == 0, $sformatf("R2 pulse widths lane %0d", l), bad_act, bad_exp);
      end else begin
        check(npulse[l] == 0, $sformatf("R4 masked lane %0d", l), npulse[l], 0);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    test_reset();
    run_frame(1, 16'hFFFF, 0, 0);   // R2 R3 R5 R6
    run_frame(3, 16'hA5C3, 0, 0);   // R4 mask latched at start
    run_frame(2, 16'h0F0F, 0, 1);   // R7 busy starts ignored
    run_frame(0, 16'hFFFF, 0, 0);   // R10 empty frame
    check(nreq == 0, "R10 no requests", nreq, 0);
    run_frame(1, 16'h8001, 1, 0);   // R2 all ones
    run_frame(2, 16'h7FFE, 2, 0);   // R2 all zeros
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule